// File: doc/BRIEF.md
# Split-Tenure Bus Master Controller

This block is the control half of a bus master on a bus where every transfer runs as two separate tenures. First comes an address tenure, opened by a one-cycle start strobe and closed by the slave's address acknowledge. Then comes a data tenure, which the master may begin only once data-bus ownership has been granted to it and no other master is signalling busy. A slave may refuse an address tenure with a retry response. The controller then waits a programmable back-off and reissues the same transfer from its address phase.

An internal requester hands over one transfer at a time: an address, a read/write flag and a size code. The controller holds these attributes and drives them on the bus. When the data tenure ends on transfer acknowledge, it returns a one-cycle completion pulse, with the captured data for reads. The data-busy line is owned by this block only while it holds the data bus. After the data tenure, the line is driven to its inactive level for a fixed number of cycles and then released to high impedance through its output enable. All bus strobes are active-low.

Top module: `split_bus_master`

## Requirements
- R1: After reset `ts_n`, `dbb_n_out` are 1, `dbb_oe`, `done` are 0, `rd_data` is 0 and `req_ready` is 1.
- R2: A request accepted while `req_ready` is 1 drives `ts_n` low for exactly one cycle, beginning on the second clock edge after acceptance when the data side is idle. `bus_addr`, `bus_rnw` and `bus_size` equal the accepted request during that cycle.
- R3: The address tenure ends only on a sampled `aack_n` low. A data-bus grant seen before that has no effect and `dbb_oe` stays 0.
- R4: A sampled `artry_n` low aborts the address tenure, even when `aack_n` is low in the same cycle. `ts_n` is then reasserted `RETRY_GAP`+1 cycles later with unchanged address, direction and size.
- R5: After the address acknowledge, the controller takes the data bus (`dbb_oe`=1, `dbb_n_out`=0) on the edge after the first cycle in which `dbg_n` is 0 and `dbb_n_in` is 1, and never earlier.
- R6: While the controller owns the data bus, `dbb_n_out` stays 0 with `dbb_oe` 1 until `ta_n` is sampled low.
- R7: On the edge that samples `ta_n` low, `dbb_n_out` goes to 1 with `dbb_oe` still 1 for `RELEASE_CYC` cycles, after which `dbb_oe` returns to 0.
- R8: `done` is high for exactly the one cycle after the edge that samples `ta_n` low. For a read (`req_rnw`=1), `rd_data` then holds `bus_data_in` from that edge. A write leaves `rd_data` unchanged.
- R9: `req_ready` is 0 from acceptance until the edge after `done`. Requests presented while it is 0 are ignored, and the held bus attributes stay constant.
- R10: `ts_n` is never asserted while `dbb_oe` is 1. A new transfer issued straight after `done` starts its address tenure no earlier than the cycle after the release ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requester offers a transfer |
| req_ready | output | 1 | Controller can accept a transfer |
| req_addr | input | AW | Transfer address |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_size | input | SZW | Transfer size code, carried to the bus unchanged |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Data captured for the last read |
| ts_n | output | 1 | Transfer start strobe, active low |
| bus_addr | output | AW | Address of the held transfer |
| bus_rnw | output | 1 | Direction of the held transfer |
| bus_size | output | SZW | Size of the held transfer |
| aack_n | input | 1 | Slave address acknowledge, active low |
| artry_n | input | 1 | Slave address retry, active low |
| dbg_n | input | 1 | Data bus grant to this master, active low |
| dbb_n_in | input | 1 | Sensed data-busy line, active low |
| dbb_n_out | output | 1 | Driven level of the data-busy line |
| dbb_oe | output | 1 | Output enable of the data-busy driver |
| ta_n | input | 1 | Transfer acknowledge, active low |
| bus_data_in | input | DW | Read data from the bus |

## Verification
The bench builds the controller with 16-bit address and data, a 2-bit size code, `RELEASE_CYC`=3 and `RETRY_GAP`=2. Because a three-cycle release lasts longer than the two cycles a fresh request needs to reach its start strobe, back-to-back transfers expose the wait on the release. The sweep covers every combination of zero to two retries, zero to two cycles of grant delay, busy delay and acknowledge delay, and both directions. Retries alternate between a plain retry and a retry coinciding with acknowledge, and expected strobe cycles, ownership windows and read data are computed from those counts.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

   typedef enum logic [1:0] {
      A_IDLE    = 2'd0,
      A_TENURE  = 2'd1,
      A_BACKOFF = 2'd2,
      A_DATA    = 2'd3
   } addr_st_e;

   typedef enum logic [1:0] {
      D_IDLE = 2'd0,
      D_ARB  = 2'd1,
      D_OWN  = 2'd2,
      D_REL  = 2'd3
   } data_st_e;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sbm_req_hold.sv
module sbm_req_hold #(
   parameter int AW  = 32,
   parameter int SZW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic [AW-1:0]  req_addr,
   input  logic           req_rnw,
   input  logic [SZW-1:0] req_size,
   input  logic           done,
   output logic           pending,
   output logic [AW-1:0]  addr_q,
   output logic           rnw_q,
   output logic [SZW-1:0] size_q
);

   logic accept;
   assign accept = req_valid && !pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         addr_q  <= '0;
         rnw_q   <= 1'b0;
         size_q  <= '0;
      end else if (accept) begin
         pending <= 1'b1;
         addr_q  <= req_addr;
         rnw_q   <= req_rnw;
         size_q  <= req_size;
      end else if (done) begin
         pending <= 1'b0;
      end
   end

   a_r9_attrs_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pending) && pending) |-> ($stable(addr_q) && $stable(rnw_q) && $stable(size_q)));

endmodule

// File: rtl/sbm_addr_ctrl.sv
module sbm_addr_ctrl
   import sbm_pkg::*;
#(
   parameter int RETRY_GAP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic data_idle,
   input  logic done,
   input  logic aack_n,
   input  logic artry_n,
   output logic ts_n,
   output logic addr_ok
);

   localparam int GW = cnt_width(RETRY_GAP);

   addr_st_e st_q;
   logic     gap_last;

   generate
      if (RETRY_GAP == 1) begin : g_gap_single
         assign gap_last = 1'b1;
      end else begin : g_gap_count
         logic [GW-1:0] gap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                gap_q <= '0;
            else if (st_q == A_BACKOFF) gap_q <= gap_q + 1'b1;
            else                       gap_q <= '0;
         end
         assign gap_last = (gap_q == GW'(RETRY_GAP - 1));
      end
   endgenerate

   // Retry outranks acknowledge when both are sampled together.
   assign addr_ok = (st_q == A_TENURE) && artry_n && !aack_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= A_IDLE;
         ts_n <= 1'b1;
      end else begin
         ts_n <= 1'b1;
         unique case (st_q)
            A_IDLE: begin
               if (pending && data_idle) begin
                  st_q <= A_TENURE;
                  ts_n <= 1'b0;
               end
            end
            A_TENURE: begin
               if (!artry_n)     st_q <= A_BACKOFF;
               else if (!aack_n) st_q <= A_DATA;
            end
            A_BACKOFF: begin
               if (gap_last) st_q <= A_IDLE;
            end
            A_DATA: begin
               if (done) st_q <= A_IDLE;
            end
            default: st_q <= A_IDLE;
         endcase
      end
   end

   a_r2_ts_single: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_n |=> ts_n);

   a_r10_ts_needs_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_n |-> data_idle);

endmodule

// File: rtl/sbm_data_ctrl.sv
module sbm_data_ctrl
   import sbm_pkg::*;
#(
   parameter int DW          = 32,
   parameter int RELEASE_CYC = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          addr_ok,
   input  logic          rnw,
   input  logic          dbg_n,
   input  logic          dbb_n_in,
   input  logic          ta_n,
   input  logic [DW-1:0] bus_data_in,
   output logic          dbb_n_out,
   output logic          dbb_oe,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic          data_idle
);

   localparam int RW = cnt_width(RELEASE_CYC);

   data_st_e st_q;
   logic     rel_last;

   generate
      if (RELEASE_CYC == 1) begin : g_rel_single
         assign rel_last = 1'b1;
      end else begin : g_rel_count
         logic [RW-1:0] rel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             rel_q <= '0;
            else if (st_q == D_REL) rel_q <= rel_q + 1'b1;
            else                    rel_q <= '0;
         end
         assign rel_last = (rel_q == RW'(RELEASE_CYC - 1));
      end
   endgenerate

   assign data_idle = (st_q == D_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= D_IDLE;
         dbb_n_out <= 1'b1;
         dbb_oe    <= 1'b0;
         done      <= 1'b0;
         rd_data   <= '0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            D_IDLE: begin
               if (addr_ok) st_q <= D_ARB;
            end
            D_ARB: begin
               if (!dbg_n && dbb_n_in) begin
                  st_q      <= D_OWN;
                  dbb_oe    <= 1'b1;
                  dbb_n_out <= 1'b0;
               end
            end
            D_OWN: begin
               if (!ta_n) begin
                  st_q      <= D_REL;
                  dbb_n_out <= 1'b1;
                  done      <= 1'b1;
                  if (rnw) rd_data <= bus_data_in;
               end
            end
            D_REL: begin
               if (rel_last) begin
                  st_q   <= D_IDLE;
                  dbb_oe <= 1'b0;
               end
            end
            default: st_q <= D_IDLE;
         endcase
      end
   end

   a_r5_own_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbb_oe) |-> $past(!dbg_n && dbb_n_in));

   a_r6_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dbb_oe && !dbb_n_out) && $past(ta_n)) |-> (dbb_oe && !dbb_n_out));

   a_r7_release_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dbb_oe) |-> $past(dbb_n_out));

   a_r8_done_after_ta: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(!ta_n));

endmodule

// File: rtl/split_bus_master.sv
module split_bus_master #(
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter int SZW         = 2,
   parameter int RELEASE_CYC = 1,
   parameter int RETRY_GAP   = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [AW-1:0]  req_addr,
   input  logic           req_rnw,
   input  logic [SZW-1:0] req_size,
   output logic           done,
   output logic [DW-1:0]  rd_data,
   output logic           ts_n,
   output logic [AW-1:0]  bus_addr,
   output logic           bus_rnw,
   output logic [SZW-1:0] bus_size,
   input  logic           aack_n,
   input  logic           artry_n,
   input  logic           dbg_n,
   input  logic           dbb_n_in,
   output logic           dbb_n_out,
   output logic           dbb_oe,
   input  logic           ta_n,
   input  logic [DW-1:0]  bus_data_in
);

   generate
      if (AW < 1 || DW < 1 || SZW < 1) begin : g_bad_width
         $error("split_bus_master: widths must be at least 1");
      end
      if (RELEASE_CYC < 1) begin : g_bad_release
         $error("split_bus_master: RELEASE_CYC must be at least 1");
      end
      if (RETRY_GAP < 1) begin : g_bad_gap
         $error("split_bus_master: RETRY_GAP must be at least 1");
      end
   endgenerate

   logic pending;
   logic data_idle;
   logic addr_ok;

   assign req_ready = !pending;

   sbm_req_hold #(.AW(AW), .SZW(SZW)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_rnw   (req_rnw),
      .req_size  (req_size),
      .done      (done),
      .pending   (pending),
      .addr_q    (bus_addr),
      .rnw_q     (bus_rnw),
      .size_q    (bus_size)
   );

   sbm_addr_ctrl #(.RETRY_GAP(RETRY_GAP)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending   (pending),
      .data_idle (data_idle),
      .done      (done),
      .aack_n    (aack_n),
      .artry_n   (artry_n),
      .ts_n      (ts_n),
      .addr_ok   (addr_ok)
   );

   sbm_data_ctrl #(.DW(DW), .RELEASE_CYC(RELEASE_CYC)) u_data (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_ok     (addr_ok),
      .rnw         (bus_rnw),
      .dbg_n       (dbg_n),
      .dbb_n_in    (dbb_n_in),
      .ta_n        (ta_n),
      .bus_data_in (bus_data_in),
      .dbb_n_out   (dbb_n_out),
      .dbb_oe      (dbb_oe),
      .done        (done),
      .rd_data     (rd_data),
      .data_idle   (data_idle)
   );

   a_r10_no_start_while_owned: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_n |-> !dbb_oe);

endmodule

// File: tb/split_bus_master_test.sv
module split_bus_master_test;

   localparam int AW  = 16;
   localparam int DW  = 16;
   localparam int SZW = 2;
   localparam int RC  = 3;
   localparam int RG  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_ready;
   logic [AW-1:0]  req_addr = '0;
   logic           req_rnw = 1'b0;
   logic [SZW-1:0] req_size = '0;
   logic           done;
   logic [DW-1:0]  rd_data;
   logic           ts_n;
   logic [AW-1:0]  bus_addr;
   logic           bus_rnw;
   logic [SZW-1:0] bus_size;
   logic           aack_n = 1'b1;
   logic           artry_n = 1'b1;
   logic           dbg_n = 1'b1;
   logic           dbb_n_in = 1'b1;
   logic           dbb_n_out;
   logic           dbb_oe;
   logic           ta_n = 1'b1;
   logic [DW-1:0]  bus_data_in = '0;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  first = 1'b1;
   bit  finished = 1'b0;
   logic [DW-1:0] exp_rd = '0;

   always #10 clk = ~clk;

   split_bus_master #(.AW(AW), .DW(DW), .SZW(SZW), .RELEASE_CYC(RC), .RETRY_GAP(RG)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_rnw(req_rnw), .req_size(req_size), .done(done),
      .rd_data(rd_data), .ts_n(ts_n), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
      .bus_size(bus_size), .aack_n(aack_n), .artry_n(artry_n), .dbg_n(dbg_n),
      .dbb_n_in(dbb_n_in), .dbb_n_out(dbb_n_out), .dbb_oe(dbb_oe), .ta_n(ta_n),
      .bus_data_in(bus_data_in)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // Cycles between a release-phase start (k=0) and later negedges.
   task automatic chk_release(input int k);
      chk(ts_n == 1'b1, "R10 no start during release", 64'(ts_n), 64'd1);
      chk(dbb_oe == (k < RC), "R7 release window", 64'(dbb_oe), 64'(k < RC));
      if (dbb_oe) chk(dbb_n_out == 1'b1, "R7 driven inactive", 64'(dbb_n_out), 64'd1);
      if (k == 1) chk(done == 1'b0, "R8 done single pulse", 64'(done), 64'd0);
   endtask

   task automatic do_txn(input logic [AW-1:0] a, input logic rw, input logic [SZW-1:0] sz,
                         input int nretry, input int gd, input int bd, input int td);
      int kts;
      logic [DW-1:0] dval;
      req_addr = a; req_rnw = rw; req_size = sz; req_valid = 1'b1;
      dbg_n = 1'b0; dbb_n_in = 1'b1;   // early grant must be ignored (R3)
      kts = first ? 2 : ((RC + 1 > 3) ? RC + 1 : 3);
      for (int k = 1; k < kts; k++) begin
         @(negedge clk);
         if (!first) begin
            chk_release(k);
            if (k == 1) chk(req_ready == 1'b1, "R9 ready after done", 64'(req_ready), 64'd1);
         end
         if ((first && k == 1) || (!first && k == 2)) begin
            chk(req_ready == 1'b0, "R9 busy after accept", 64'(req_ready), 64'd0);
            req_valid = 1'b0;
         end
      end
      @(negedge clk);
      first = 1'b0;
      for (int at = 0; at <= nretry; at++) begin
         if (at > 0) begin
            for (int g = 0; g < RG; g++) begin
               @(negedge clk);
               chk(ts_n == 1'b1, "R4 back-off", 64'(ts_n), 64'd1);
            end
            @(negedge clk);
         end
         chk(ts_n == 1'b0, "R2 start strobe", 64'(ts_n), 64'd0);
         chk(bus_addr == a && bus_rnw == rw && bus_size == sz, "R4 attributes kept",
             {bus_addr, bus_rnw, bus_size}, {a, rw, sz});
         if (at < nretry) begin
            artry_n = 1'b0;
            aack_n  = (at % 2 == 1) ? 1'b0 : 1'b1;   // odd attempts: retry beats ack
         end else begin
            aack_n = 1'b0;
         end
         @(negedge clk);
         artry_n = 1'b1; aack_n = 1'b1;
         chk(ts_n == 1'b1, "R2 one-cycle strobe", 64'(ts_n), 64'd1);
         chk(dbb_oe == 1'b0, "R3 no ownership in address phase", 64'(dbb_oe), 64'd0);
      end
      // Arbitration: grant after gd cycles, busy clears after bd cycles.
      req_addr = ~a; req_valid = 1'b1;   // must be ignored (R9)
      for (int i = 0; i <= 2; i++) begin
         if (i > 0) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk(dbb_oe == 1'b0, "R5 wait for grant and idle bus", 64'(dbb_oe), 64'd0);
         end
         dbg_n    = (i >= gd) ? 1'b0 : 1'b1;
         dbb_n_in = (i >= bd) ? 1'b1 : 1'b0;
         if (i >= gd && i >= bd) break;
      end
      @(negedge clk);
      req_valid = 1'b0;
      dbg_n = 1'b1;
      chk(dbb_oe == 1'b1 && dbb_n_out == 1'b0, "R5 ownership taken",
          {dbb_oe, dbb_n_out}, 64'b10);
      dval = DW'({a[7:0], a[15:8]} ^ 16'h5a3c);
      bus_data_in = ~dval;
      for (int j = 0; j <= td; j++) begin
         if (j > 0) @(negedge clk);
         chk(dbb_oe && !dbb_n_out && !done, "R6 busy held", {dbb_oe, dbb_n_out, done}, 64'b100);
         if (j == td) begin ta_n = 1'b0; bus_data_in = dval; end
      end
      @(negedge clk);
      ta_n = 1'b1; bus_data_in = ~dval;
      if (rw) exp_rd = dval;
      chk(done == 1'b1, "R8 done pulse", 64'(done), 64'd1);
      chk(rd_data == exp_rd, "R8 read data", 64'(rd_data), 64'(exp_rd));
      chk(dbb_oe && dbb_n_out, "R7 inactive after ta", {dbb_oe, dbb_n_out}, 64'b11);
      chk(bus_addr == a, "R9 ignored request", 64'(bus_addr), 64'(a));
   endtask

   initial begin
      int idx;
      repeat (3) @(negedge clk);
      chk(ts_n && dbb_n_out && !dbb_oe && !done && req_ready && rd_data == '0, "R1 reset state",
          {ts_n, dbb_n_out, dbb_oe, done, req_ready, rd_data}, {5'b11001, 16'h0});
      rst_n = 1'b1;
      @(negedge clk);
      chk(ts_n == 1'b1 && dbb_oe == 1'b0, "R1 idle after reset", {ts_n, dbb_oe}, 64'b10);
      idx = 0;
      for (int nr = 0; nr < 3; nr++)
         for (int gd = 0; gd < 3; gd++)
            for (int bd = 0; bd < 3; bd++)
               for (int td = 0; td < 3; td++)
                  for (int rw = 0; rw < 2; rw++) begin
                     do_txn(AW'(16'h1000 + idx * 16'h0131), rw[0], idx[SZW-1:0], nr, gd, bd, td);
                     idx++;
                  end
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         chk_release(k);
         chk(req_ready == 1'b1, "R9 idle ready", 64'(req_ready), 64'd1);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule